// File: doc/BRIEF.md
# External-Clock Conversion Sequencer

This block runs the timing of a serial converter frame when the host's serial clock itself steps the successive-approximation conversion. A command receiver recognises the start bit of a control byte, pulses `start` together with the chosen acquisition length, and from then on the block counts falling serial-clock edges. One serial-clock period before the first data bit it raises a strobe. On the next falling edge it loads the 16-bit conversion result from a parallel input and presents it on the data line, most significant bit first, followed by zeros once the last bit has gone.

Two acquisition lengths are offered. A short frame is 24 falling edges long and puts the strobe after edge 7 and the first data bit on edge 8. A long frame is 32 edges long and puts them after edge 15 and on edge 16. Whenever chip-select is high, serial-clock edges are ignored and the frame resumes where it stopped, so the host may move the frame in byte-sized pieces. Both serial outputs carry an enable that drops while chip-select is high. A calibration-busy input forces the strobe high for the length of an external-clock calibration.

The serial clock is presented as a one-cycle `sclk_fall` pulse synchronised to the system clock `clk`.

Top module: `xclk_conv_seq`

## Requirements
- R1: After synchronous reset (`rst_n` low), `sstrb`, `dout` and `done` are 0 and no frame is in progress.
- R2: In a short frame (`long_acq`=0 at start), `sstrb` goes to 1 after the 7th counted falling edge after `start` and returns to 0 on the 8th, so it lasts exactly one serial-clock period.
- R3: In a short frame, `dout` shows result bit 15 after the 8th counted falling edge, and each following falling edge presents the next lower bit, down to bit 0 after the 23rd.
- R4: In a long frame (`long_acq`=1 at start), the strobe is 1 from the 15th to the 16th counted edge, and result bit 15 appears after the 16th.
- R5: After bit 0 has been presented, further falling edges put 0 on `dout`.
- R6: `done` is 1 for exactly one clock after the 24th (short) or 32nd (long) counted falling edge. The frame then ends, and later edges have no effect.
- R7: `dout_oe` and `sstrb_oe` equal the inverse of `cs_n` at all times.
- R8: Falling edges that arrive while `cs_n` is high are not counted. The frame continues from the same count once `cs_n` is low again.
- R9: An `abort` pulse ends the frame at once. `sstrb` and `dout` go to 0, and `done` is not raised for that frame.
- R10: A `start` during a frame discards that frame and begins a new one from count 0 with the newly given length.
- R11: While `cal_busy` is 1, `sstrb` is 1.
- R12: `long_acq` is sampled only at `start`. A change during a frame has no effect on that frame.
- R13: `result` is sampled on the edge that presents bit 15. Later changes do not alter the bits that are shifted out.
- R14: Falling edges outside a frame leave `sstrb`, `dout` and `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_fall | input | 1 | One-cycle pulse marking a serial-clock falling edge |
| cs_n | input | 1 | Active-low chip-select |
| start | input | 1 | Start-bit recognised; begins a frame |
| long_acq | input | 1 | Frame length at start: 0 = 24 edges, 1 = 32 edges |
| abort | input | 1 | Ends the current frame without `done` |
| cal_busy | input | 1 | External-clock calibration in progress; forces the strobe high |
| result | input | 16 | Parallel conversion result |
| sstrb | output | 1 | Strobe value |
| sstrb_oe | output | 1 | Strobe output enable |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data output enable |
| done | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench builds the block with its defaults: a 16-bit result and the first data bit on edge 8 or edge 16. These are the only values that put the strobe and data positions in the places the host expects, so the edge numbers checked are the real ones for both frame lengths. A behavioural model counts edges with integers and predicts the strobe, data and done pulse on every clock. The scenarios bring within reach a frame paused by chip-select, a mode or result change mid-frame, an abort, a restart, and calibration.

// File: rtl/xcs_pkg.sv
// Shared types for the external-clock conversion sequencer.
// Assumes nothing beyond a 1800-2017 compiler.
package xcs_pkg;
    typedef enum logic {
        ACQ_SHORT = 1'b0,
        ACQ_LONG  = 1'b1
    } acq_len_e;
endpackage

// File: rtl/xcs_counter.sv
// Edge counter: counts qualified serial-clock falling edges within a frame and
// decodes the strobe, first-bit, shift and end positions for the chosen length.
// Assumes sclk_fall is a single-cycle pulse synchronous to clk.
module xcs_counter
    import xcs_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SHORT_MSB = 8,
    parameter int LONG_MSB  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_fall,
    input  logic cs_n,
    input  logic start,
    input  logic abort,
    input  logic long_i,
    output logic adv,
    output logic strobe_hit,
    output logic msb_hit,
    output logic shift_hit,
    output logic done_o
);
    localparam int LAST_EDGE = LONG_MSB + DATA_W;
    localparam int CNT_W     = $clog2(LAST_EDGE + 1);

    logic             busy_q;
    acq_len_e         len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] msb_pos;
    logic [CNT_W-1:0] end_pos;
    logic             end_hit;

    // Qualified edge: frame running, chip selected, no control event this cycle.
    assign adv     = busy_q & sclk_fall & ~cs_n & ~start & ~abort;
    assign cnt_nx  = cnt_q + 1'b1;
    assign msb_pos = (len_q == ACQ_LONG) ? CNT_W'(LONG_MSB) : CNT_W'(SHORT_MSB);
    assign end_pos = msb_pos + CNT_W'(DATA_W);

    // Position decode on the count reached by this edge.
    assign strobe_hit = adv && (cnt_nx == msb_pos - 1'b1);
    assign msb_hit    = adv && (cnt_nx == msb_pos);
    assign shift_hit  = adv && (cnt_nx >  msb_pos);
    assign end_hit    = adv && (cnt_nx == end_pos);

    // Frame state: abort wins over start, start over edge counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            len_q  <= ACQ_SHORT;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            len_q  <= acq_len_e'(long_i);
        end else if (adv) begin
            cnt_q <= cnt_nx;
            if (end_hit) busy_q <= 1'b0;
        end
    end

    // End-of-frame pulse, one clock wide.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= end_hit;
    end

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !start && !abort) |=> $stable(cnt_q));
    assert_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < end_pos));
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy_q && !done_o));
endmodule

// File: rtl/xcs_strobe.sv
// Strobe generator: holds the strobe for exactly one serial-clock period
// before the first data bit and ORs in the calibration-busy level.
// Assumes strobe_hit only occurs on a qualified edge (adv).
module xcs_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic strobe_hit,
    input  logic start,
    input  logic abort,
    input  logic cal_busy,
    output logic sstrb_o
);
    logic pulse_q;

    // Set on the strobe position, clear on the next qualified edge or control event.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pulse_q <= 1'b0;
        else if (start || abort)    pulse_q <= 1'b0;
        else if (adv)               pulse_q <= strobe_hit;
    end

    assign sstrb_o = pulse_q | cal_busy;

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && adv) |=> !pulse_q);
endmodule

// File: rtl/xcs_shifter.sv
// Result shifter: captures the parallel result on the first-bit edge and moves
// it out MSB first, filling with zeros behind it.
// Assumes load and shift never occur in the same cycle.
module xcs_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              bit_o
);
    logic [DATA_W-1:0] sr_q;

    // Capture, shift left with zero fill, or clear on frame control.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sr_q <= '0;
        else if (load)     sr_q <= din;
        else if (shift)    sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end

    assign bit_o = sr_q[DATA_W-1];

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr) |=> ($countones(sr_q) <= $past($countones(sr_q))));
endmodule

// File: rtl/xclk_conv_seq.sv
// External-clock conversion sequencer top: ties the edge counter, strobe
// generator and result shifter together and gates output enables with chip-select.
// Assumes a command receiver supplies start/long_acq/abort and sclk_fall pulses.
module xclk_conv_seq #(
    parameter int DATA_W    = 16,
    parameter int SHORT_MSB = 8,
    parameter int LONG_MSB  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              cs_n,
    input  logic              start,
    input  logic              long_acq,
    input  logic              abort,
    input  logic              cal_busy,
    input  logic [DATA_W-1:0] result,
    output logic              sstrb,
    output logic              sstrb_oe,
    output logic              dout,
    output logic              dout_oe,
    output logic              done
);
    logic adv, strobe_hit, msb_hit, shift_hit;

    xcs_counter #(
        .DATA_W(DATA_W), .SHORT_MSB(SHORT_MSB), .LONG_MSB(LONG_MSB)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .cs_n(cs_n),
        .start(start), .abort(abort), .long_i(long_acq),
        .adv(adv), .strobe_hit(strobe_hit), .msb_hit(msb_hit),
        .shift_hit(shift_hit), .done_o(done)
    );

    xcs_strobe u_stb (
        .clk(clk), .rst_n(rst_n), .adv(adv), .strobe_hit(strobe_hit),
        .start(start), .abort(abort), .cal_busy(cal_busy), .sstrb_o(sstrb)
    );

    xcs_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .clr(start | abort), .load(msb_hit),
        .shift(shift_hit), .din(result), .bit_o(dout)
    );

    // Outputs are driven only while the chip is selected.
    assign dout_oe  = ~cs_n;
    assign sstrb_oe = ~cs_n;

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/xclk_conv_seq_tb.sv
module xclk_conv_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_fall = 1'b0, cs_n = 1'b1, start = 1'b0, long_acq = 1'b0;
    logic abort = 1'b0, cal_busy = 1'b0;
    logic [15:0] result = '0;
    logic sstrb, sstrb_oe, dout, dout_oe, done;

    int total = 0, bad = 0, done_seen = 0;
    string cur_tag = "R1";

    // Behavioural model state
    bit mb = 0, mlong = 0, msst = 0, mdone = 0;
    int mc = 0;
    logic [15:0] mval = '0;

    xclk_conv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .cs_n(cs_n),
        .start(start), .long_acq(long_acq), .abort(abort), .cal_busy(cal_busy),
        .result(result), .sstrb(sstrb), .sstrb_oe(sstrb_oe), .dout(dout),
        .dout_oe(dout_oe), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_dout();
        int msb = mlong ? 16 : 8;
        int k = mc - msb;
        if (mc >= msb && k < 16) return mval[15 - k];
        return 1'b0;
    endfunction

    // Reference model update and per-clock comparison
    always @(posedge clk) begin
        int msb, stb, last;
        if (!rst_n) begin
            mb = 0; mc = 0; msst = 0; mdone = 0; mlong = 0;
        end else begin
            mdone = 0;
            if (abort) begin
                mb = 0; mc = 0; msst = 0;
            end else if (start) begin
                mb = 1; mc = 0; msst = 0; mlong = long_acq;
            end else if (mb && sclk_fall && !cs_n) begin
                msb = mlong ? 16 : 8; stb = msb - 1; last = msb + 16;
                mc++;
                msst = (mc == stb);
                if (mc == msb) mval = result;
                if (mc == last) begin mdone = 1; mb = 0; end
            end
        end
        #2;
        chk("R7", "dout_oe", dout_oe, !cs_n);
        chk("R7", "sstrb_oe", sstrb_oe, !cs_n);
        if (rst_n) begin
            chk(cur_tag, "sstrb", sstrb, msst | cal_busy);
            chk(cur_tag, "dout", dout, exp_dout());
            chk(cur_tag, "done", done, mdone);
            if (done) done_seen++;
        end
    end

    task automatic edges(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sclk_fall = 1'b1;
            @(negedge clk) sclk_fall = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic kick(logic lg);
        @(negedge clk) begin start = 1'b1; long_acq = lg; end
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sstrb", sstrb, 0);
        chk("R1", "dout", dout, 0);
        chk("R1", "done", done, 0);
        cs_n = 1'b0;

        cur_tag = "R14";
        edges(3);
        chk("R14", "dout idle", dout, 0);
        chk("R14", "done idle", done_seen, 0);

        cur_tag = "R2/R3/R5";
        result = 16'hA5C3;
        kick(1'b0);
        edges(8);
        result = 16'h1234;        // R13: change after capture
        cur_tag = "R13";
        edges(20);
        chk("R6", "short done count", done_seen, 1);

        cur_tag = "R4/R12";
        result = 16'h8001;
        kick(1'b1);
        edges(3);
        long_acq = 1'b0;          // R12: no effect on running frame
        edges(33);
        chk("R6", "long done count", done_seen, 2);

        cur_tag = "R8";
        result = 16'h6F0D;
        kick(1'b0);
        edges(10);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk("R7", "dout_oe deselected", dout_oe, 0);
        chk("R7", "sstrb_oe deselected", sstrb_oe, 0);
        edges(5);
        @(negedge clk) cs_n = 1'b0;
        edges(13);
        chk("R8", "no done before 24 counted", done_seen, 2);
        edges(1);
        chk("R8", "done after resume", done_seen, 3);

        cur_tag = "R9";
        result = 16'hFFFF;
        kick(1'b1);
        edges(20);
        @(negedge clk) abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk("R9", "dout after abort", dout, 0);
        chk("R9", "sstrb after abort", sstrb, 0);
        edges(20);
        chk("R9", "no done", done_seen, 3);

        cur_tag = "R10";
        result = 16'h5A5A;
        kick(1'b0);
        edges(5);
        kick(1'b1);
        edges(31);
        chk("R10", "no early done", done_seen, 3);
        edges(2);
        chk("R10", "restart done", done_seen, 4);

        cur_tag = "R11";
        @(negedge clk) cal_busy = 1'b1;
        @(negedge clk);
        chk("R11", "cal strobe high", sstrb, 1);
        @(negedge clk) cal_busy = 1'b0;
        @(negedge clk);
        chk("R11", "cal strobe released", sstrb, 0);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule